// File: doc/BRIEF.md
# Position Compare Unit with Offset Reload

This block watches a running position count and raises a single-cycle match pulse when the count reaches a target value. The target can be supplied in two ways, chosen by a mode input. In instant mode, software writes a new target whenever it needs to, using a value bus and a write strobe. In offset mode, the block watches a sample clock level. On each rising edge of that clock it captures the position count present at that moment, adds a signed offset to it, and uses the sum as the next target. This lets a sampled position set up a compare point a fixed distance ahead of it or behind it.

The sample clock is a plain level sampled in the system clock domain. The block finds its rising edge by comparing the current level with the level seen one cycle earlier. The active target is always visible on an output. The match pulse is edge-like: it fires once when equality is first reached. It fires again only after the target is reloaded, or after the count leaves the target and comes back.

Top module: `pos_cmp_unit`

## Requirements
- R1: While reset is asserted, the target output reads 0 and the match output reads 0.
- R2: With mode 0 (instant), a cycle with the write strobe high loads the value on the software bus, and the target output shows it from the next cycle.
- R3: With mode 0 (instant), rising edges of the sample clock leave the target unchanged.
- R4: With mode 1 (offset), a cycle where the sample clock is high and was low in the previous cycle loads the count of that cycle plus the offset, and the target output shows it from the next cycle.
- R5: The offset is a two's-complement value of the count width, and the sum wraps modulo 2 to the power of the count width (for width 4: count 1 with offset 0xE gives 0xF).
- R6: With mode 1 (offset), the software write strobe leaves the target unchanged.
- R7: A sample clock that stays high, or that falls, loads nothing. A level that is already high when reset is released is not a rising edge.
- R8: In the cycle after the first cycle in which the count equals the target, the match output is high for exactly one cycle, even if the count stays at the target.
- R9: If the count leaves the target and later returns to it, a new match pulse is produced.
- R10: Any load re-arms the match, including a load of the value already held. While the count sits on the target, such a load produces a new pulse one cycle after the target output updates.
- R11: In a cycle where a load occurs and the count equals the old target, the match is still reported for the old target, and the new target is compared from the next cycle on.
- R12: After reset, no match is produced until the count differs from the target or a load occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pos_cnt | input | CNT_W | Running position count |
| samp_clk | input | 1 | Sample clock level |
| mode_offset | input | 1 | 0 = instant load, 1 = offset reload |
| offset_val | input | CNT_W | Signed offset added to the captured count |
| sw_cmp_val | input | CNT_W | Software target value |
| sw_cmp_wr | input | 1 | Software target write strobe |
| match_pulse | output | 1 | One-cycle match indication |
| cmp_val_out | output | CNT_W | Target currently in use |

## Verification
Two events can fall in the same cycle: a reload of the target, and equality between the count and the old target. The bench provokes this by parking the count on the current target and issuing a software write, or by issuing a sample clock edge in that same cycle. It then expects a pulse for the old target and, independently, the new target on the output one cycle later. It also reloads the same value while the count is parked, and expects a fresh pulse. All expectations come from a cycle model built only from the requirements. The model covers an exhaustive sweep of every count and offset pair at a width of 4.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic {
        MODE_INSTANT = 1'b0,
        MODE_OFFSET  = 1'b1
    } cmp_mode_e;

endpackage

// File: rtl/pcu_edge_det.sv
// Rising-edge finder for a level sampled in the clk domain.
// History resets high so a level already high at reset release is no edge (R7).
module pcu_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);

    typedef struct packed {
        logic lvl;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = lvl_i;
        rise_o   = lvl_i & ~st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lvl <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pcu_cmp_load.sv
// Target register with mode-selected load source.
module pcu_cmp_load
    import pcu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cmp_mode_e    mode_i,
    input  logic         rise_i,
    input  logic [W-1:0] pos_i,
    input  logic [W-1:0] ofs_i,
    input  logic [W-1:0] sw_val_i,
    input  logic         sw_wr_i,
    output logic         load_o,
    output logic [W-1:0] cmp_o
);

    typedef struct packed {
        logic [W-1:0] cmp;
    } load_st_t;

    load_st_t     st_d, st_q;
    logic [W-1:0] reload_sum;
    logic [W-1:0] src_val;

    always_comb begin
        // two's-complement add, wraps at width W (R5)
        reload_sum = pos_i + ofs_i;
        st_d       = st_q;
        unique case (mode_i)
            MODE_OFFSET: begin
                load_o  = rise_i;          // R4, R6
                src_val = reload_sum;
            end
            default: begin
                load_o  = sw_wr_i;         // R2, R3
                src_val = sw_val_i;
            end
        endcase
        if (load_o) begin
            st_d.cmp = src_val;
        end
        cmp_o = st_q.cmp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cmp <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pcu_match.sv
// Equality detector with arm flag; pulse is registered.
module pcu_match #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pos_i,
    input  logic [W-1:0] cmp_i,
    input  logic         load_i,
    output logic         match_o
);

    typedef struct packed {
        logic armed;
        logic match;
    } match_st_t;

    match_st_t st_d, st_q;
    logic      eq;

    always_comb begin
        eq          = (pos_i == cmp_i);
        st_d        = st_q;
        // report against the target in use this cycle (R11)
        st_d.match  = eq & st_q.armed;
        // re-arm on reload (R10) or when the count leaves the target (R9)
        st_d.armed  = load_i | ~eq;
        match_o     = st_q.match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.armed <= 1'b0;           // R12
            st_q.match <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pos_cmp_unit.sv
module pos_cmp_unit
    import pcu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] pos_cnt,
    input  logic             samp_clk,
    input  logic             mode_offset,
    input  logic [CNT_W-1:0] offset_val,
    input  logic [CNT_W-1:0] sw_cmp_val,
    input  logic             sw_cmp_wr,
    output logic             match_pulse,
    output logic [CNT_W-1:0] cmp_val_out
);

    logic      samp_rise;
    logic      load_stb;
    cmp_mode_e mode_sel;

    assign mode_sel = cmp_mode_e'(mode_offset);

    pcu_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (samp_clk),
        .rise_o (samp_rise)
    );

    pcu_cmp_load #(.W(CNT_W)) u_load (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode_sel),
        .rise_i   (samp_rise),
        .pos_i    (pos_cnt),
        .ofs_i    (offset_val),
        .sw_val_i (sw_cmp_val),
        .sw_wr_i  (sw_cmp_wr),
        .load_o   (load_stb),
        .cmp_o    (cmp_val_out)
    );

    pcu_match #(.W(CNT_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .pos_i   (pos_cnt),
        .cmp_i   (cmp_val_out),
        .load_i  (load_stb),
        .match_o (match_pulse)
    );

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] pos_cnt,
    input logic         mode_offset,
    input logic [W-1:0] offset_val,
    input logic [W-1:0] sw_cmp_val,
    input logic         sw_cmp_wr,
    input logic         samp_rise,
    input logic         load_stb,
    input logic         match_pulse,
    input logic [W-1:0] cmp_val_out
);

    logic [W-1:0] exp_sum;
    logic         at_target;

    assign exp_sum   = pos_cnt + offset_val;
    assign at_target = (pos_cnt == cmp_val_out);

    p_rst_zero_r1: assert property (@(posedge clk) !rst_n |-> (cmp_val_out == '0 && !match_pulse));

    p_hold_no_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |=> $stable(cmp_val_out));

    p_instant_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && !mode_offset) |=> cmp_val_out == $past(sw_cmp_val));

    p_instant_no_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_offset && !sw_cmp_wr) |-> !load_stb);

    p_offset_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && mode_offset) |=> cmp_val_out == $past(exp_sum));

    p_offset_sw_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_offset && !samp_rise) |-> !load_stb);

    p_match_means_eq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> $past(at_target));

    p_no_repeat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (at_target && $past(at_target) && !$past(load_stb)) |=> !match_pulse);

endmodule

bind pos_cmp_unit pcu_checker #(.W(CNT_W)) u_pcu_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pos_cnt     (pos_cnt),
    .mode_offset (mode_offset),
    .offset_val  (offset_val),
    .sw_cmp_val  (sw_cmp_val),
    .sw_cmp_wr   (sw_cmp_wr),
    .samp_rise   (samp_rise),
    .load_stb    (load_stb),
    .match_pulse (match_pulse),
    .cmp_val_out (cmp_val_out)
);

// File: tb/tb_pos_cmp_unit.sv
module tb_pos_cmp_unit;

    localparam int W = 4;
    localparam int N = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pos_cnt = '0;
    logic         samp_clk = 1'b1;
    logic         mode_offset = 1'b0;
    logic [W-1:0] offset_val = '0;
    logic [W-1:0] sw_cmp_val = '0;
    logic         sw_cmp_wr = 1'b0;
    logic         match_pulse;
    logic [W-1:0] cmp_val_out;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // requirement-level cycle model
    logic [W-1:0] m_cmp;
    logic         m_armed, m_sprev, m_match;

    always #5 clk = ~clk;

    pos_cmp_unit #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .pos_cnt(pos_cnt), .samp_clk(samp_clk),
        .mode_offset(mode_offset), .offset_val(offset_val),
        .sw_cmp_val(sw_cmp_val), .sw_cmp_wr(sw_cmp_wr),
        .match_pulse(match_pulse), .cmp_val_out(cmp_val_out)
    );

    task automatic check(input string tag);
        vectors++;
        if (cmp_val_out !== m_cmp || match_pulse !== m_match) begin
            miscompares++;
            $display("FAIL %s: cmp=%0d match=%0b expected cmp=%0d match=%0b",
                     tag, cmp_val_out, match_pulse, m_cmp, m_match);
        end
    endtask

    task automatic step(input logic [W-1:0] c, input logic s, input logic md,
                        input logic [W-1:0] o, input logic w, input logic [W-1:0] wv,
                        input string tag);
        logic         rise, load, eq;
        logic [W-1:0] nv;
        pos_cnt = c; samp_clk = s; mode_offset = md;
        offset_val = o; sw_cmp_wr = w; sw_cmp_val = wv;
        rise = s & ~m_sprev;
        load = md ? rise : w;
        nv   = md ? W'(int'(c) + int'(o)) : wv;
        eq   = (c == m_cmp);
        m_match = eq & m_armed;
        m_armed = load | ~eq;
        if (load) m_cmp = nv;
        m_sprev = s;
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #1_500_000;
        miscompares++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        m_cmp = '0; m_armed = 1'b0; m_sprev = 1'b1; m_match = 1'b0;
        pos_cnt = 4'd5;
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;

        // R7/R12: level high at release is no edge; count 5 != 0 then arms
        step(4'd5, 1'b1, 1'b1, 4'd3, 1'b0, 4'd0, "R7 high at release");
        step(4'd0, 1'b1, 1'b1, 4'd3, 1'b0, 4'd0, "R12 first equal");
        step(4'd0, 1'b1, 1'b1, 4'd3, 1'b0, 4'd0, "R8 held");

        // R4/R5: exhaustive count x offset in offset mode
        for (int c = 0; c < N; c++) begin
            for (int o = 0; o < N; o++) begin
                step(W'(c), 1'b0, 1'b1, W'(o), 1'b1, W'(9), "R6 sw ignored low");
                step(W'(c), 1'b1, 1'b1, W'(o), 1'b0, W'(0),
                     o >= N/2 ? "R5 negative offset" : "R4 offset reload");
            end
        end
        // R7: held high and falling edges load nothing
        step(4'd2, 1'b1, 1'b1, 4'd4, 1'b0, 4'd0, "R7 held high");
        step(4'd3, 1'b0, 1'b1, 4'd4, 1'b0, 4'd0, "R7 falling");
        step(4'd3, 1'b0, 1'b1, 4'd4, 1'b1, 4'd1, "R6 sw ignored");

        // R2/R8: instant mode, every target swept with every count
        for (int v = 0; v < N; v++) begin
            step(W'(v + 8), 1'b0, 1'b0, 4'd0, 1'b1, W'(v), "R2 instant write");
            for (int c = 0; c < N; c++) begin
                step(W'(c), 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, "R8 count sweep");
            end
        end
        // R3: sample edges ignored in instant mode
        step(4'd1, 1'b1, 1'b0, 4'd5, 1'b0, 4'd0, "R3 edge ignored");
        step(4'd1, 1'b0, 1'b0, 4'd5, 1'b0, 4'd0, "R3 edge ignored");
        step(4'd1, 1'b1, 1'b0, 4'd5, 1'b0, 4'd0, "R3 edge ignored");

        // R9: leave and return
        step(4'd6, 1'b0, 1'b0, 4'd0, 1'b1, 4'd7, "R2 write 7");
        step(4'd7, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, "R9 reach");
        step(4'd7, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, "R9 pulse");
        step(4'd7, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, "R9 no repeat");
        step(4'd8, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, "R9 leave");
        step(4'd7, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, "R9 return");
        step(4'd7, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, "R9 pulse again");

        // R10: reload of same value while parked
        step(4'd7, 1'b0, 1'b0, 4'd0, 1'b1, 4'd7, "R10 same reload");
        step(4'd7, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, "R10 rearmed");
        step(4'd7, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, "R10 pulse");

        // R11: collision of load and equality (instant then offset)
        step(4'd3, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, "R11 away");
        step(4'd7, 1'b0, 1'b0, 4'd0, 1'b1, 4'd9, "R11 collide sw");
        step(4'd9, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, "R11 old match");
        step(4'd9, 1'b0, 1'b1, 4'd2, 1'b0, 4'd0, "R11 new match");
        step(4'd4, 1'b0, 1'b1, 4'd2, 1'b0, 4'd0, "R11 away");
        step(4'd9, 1'b1, 1'b1, 4'd2, 1'b0, 4'd0, "R11 collide edge");
        step(4'd11, 1'b1, 1'b1, 4'd2, 1'b0, 4'd0, "R11 old match offset");
        step(4'd11, 1'b0, 1'b1, 4'd2, 1'b0, 4'd0, "R11 new match offset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule